// File: doc/BRIEF.md
# Quad-Channel DAC Serial Command Decoder

This block sits in front of a four-channel digital-to-analog converter core and turns a three-wire serial command stream into register state. A host drives a serial clock, a data line and an active-low chip select. While chip select is low, each rising serial clock edge shifts one data bit in, most significant bit first. When chip select goes high again, the block looks at the word. If the bit count is exactly the configured word length, it decodes the word. Any other count means the word is dropped.

The top four bits of a word decide what happens. The all-channel shutdown flag sits at the top, the single-channel shutdown flag comes next, and a two-bit channel address follows. The remaining bits are the conversion code. The all-channel flag wins over everything else. The single-channel flag shuts down only the addressed channel. With both flags clear, the code goes into the addressed channel's input register and that channel comes out of shutdown. A synchronous active-low load strobe copies all four input registers into the output registers in one clock. The serial pins are brought into the system clock domain through two-flop synchronizers. The default code width is 12 bits, which gives a 16-bit word. A parameter selects a 10-bit code with a 14-bit word.

Top module: `dacdec_top`

## Requirements
- R1: During and after reset, every input register and output register reads zero and all four shutdown flags read one.
- R2: Words are shifted in MSB first. Bit W-1 is the all-shutdown flag and bit W-2 is the single-shutdown flag. Bits W-3:W-4 are the channel address, where 0 is A, 1 is B, 2 is C and 3 is D. The low W-4 bits are the code. For the default, W is 16.
- R3: When both flags are zero, the code is written into the addressed input register and that channel's shutdown flag is cleared. Other channels are unchanged.
- R4: When the all-shutdown flag is zero and the single-shutdown flag is one, only the addressed channel's shutdown flag is set. No input register changes.
- R5: When the all-shutdown flag is one, all four shutdown flags are set whatever the other bits hold. No input register changes.
- R6: A frame whose bit count differs from W, whether shorter or longer, is discarded with no change to any output.
- R7: Serial clock edges while chip select is high have no effect.
- R8: A clock edge that samples the load strobe low copies all four input registers into the output registers. While the strobe is high, the output registers hold their values.
- R9: With CODE_W set to 10, 14-bit words are decoded with the same field order: flags at bits 13 and 12, address at bits 11:10, code at bits 9:0. A 16-bit frame sent to that variant is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| csn_i | input | 1 | Chip select, active low |
| ldn_i | input | 1 | Load strobe, active low, synchronous |
| in_code_o | output | 4*CODE_W | Input registers, channel A in the low slice |
| out_code_o | output | 4*CODE_W | Output registers, channel A in the low slice |
| shdn_o | output | 4 | Shutdown flags, bit 0 is channel A |

## Verification
The hardest case to reach from the pins is a frame with the wrong length. It looks valid at every bit, and it differs from a good frame only in the count seen when chip select rises. The stimulus sends frames one bit short and one bit long. It also sends a full 16-bit frame to the 14-bit variant. Random frames with a small chance of an off-by-one length are interleaved with good ones, so a dropped word can be followed at once by an accepted one. Serial clock bursts with chip select high check that no idle edge leaks into the count.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;

    localparam int NCH    = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        OP_WRITE    = 2'd0,
        OP_SHDN_ONE = 2'd1,
        OP_SHDN_ALL = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    // top4 = {all-shutdown, single-shutdown, addr[1], addr[0]}
    function automatic hdr_t decode_hdr(input logic [3:0] top4);
        hdr_t h;
        h.addr = top4[1:0];
        if (top4[3])
            h.op = OP_SHDN_ALL;
        else if (top4[2])
            h.op = OP_SHDN_ONE;
        else
            h.op = OP_WRITE;
        return h;
    endfunction

endpackage

// File: rtl/dacdec_sync.sv
module dacdec_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= RST_VAL[b];
                sync_o[b] <= RST_VAL[b];
            end else begin
                stage1[b] <= async_i[b];
                sync_o[b] <= stage1[b];
            end
        end
    end
endmodule

// File: rtl/dacdec_shift.sv
module dacdec_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              csn_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic             sclk_d, csn_d;
    logic             sclk_rise, csn_rise, csn_fall;
    logic [CNT_W-1:0] cnt;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign csn_rise  = csn_s & ~csn_d;
    assign csn_fall  = ~csn_s & csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
            cnt    <= '0;
            word   <= '0;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
            if (csn_fall) begin
                cnt <= '0;
            end else if (sclk_rise && !csn_s) begin
                word <= {word[WORD_W-2:0], sdata_s};
                if (cnt != CNT_SAT)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    assign word_valid = csn_rise && (cnt == CNT_FULL);
endmodule

// File: rtl/dacdec_regs.sv
module dacdec_regs
    import dacdec_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  hdr_t                  hdr,
    input  logic [CODE_W-1:0]     code,
    input  logic                  ldn_i,
    output logic [NCH*CODE_W-1:0] in_flat,
    output logic [NCH*CODE_W-1:0] out_flat,
    output logic [NCH-1:0]        shdn
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CODE_W-1:0] in_q, out_q;
        logic              hit;

        assign hit = (hdr.addr == ADDR_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                in_q    <= '0;
                out_q   <= '0;
                shdn[c] <= 1'b1;
            end else begin
                if (!ldn_i)
                    out_q <= in_q;
                if (cmd_valid) begin
                    case (hdr.op)
                        OP_WRITE: if (hit) begin
                            in_q    <= code;
                            shdn[c] <= 1'b0;
                        end
                        OP_SHDN_ONE: if (hit) shdn[c] <= 1'b1;
                        OP_SHDN_ALL: shdn[c] <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end

        assign in_flat[c*CODE_W +: CODE_W]  = in_q;
        assign out_flat[c*CODE_W +: CODE_W] = out_q;
    end
endmodule

// File: rtl/dacdec_top.sv
module dacdec_top
    import dacdec_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_i,
    input  logic                  sdata_i,
    input  logic                  csn_i,
    input  logic                  ldn_i,
    output logic [NCH*CODE_W-1:0] in_code_o,
    output logic [NCH*CODE_W-1:0] out_code_o,
    output logic [NCH-1:0]        shdn_o
);
    localparam int WORD_W = CODE_W + 4;

    logic [2:0]        pins_s;
    logic              cmd_valid;
    logic [WORD_W-1:0] cmd_word;
    hdr_t              hdr;

    dacdec_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i ({csn_i, sdata_i, sclk_i}),
        .sync_o  (pins_s)
    );

    dacdec_shift #(.WORD_W(WORD_W)) shift_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (pins_s[0]),
        .sdata_s    (pins_s[1]),
        .csn_s      (pins_s[2]),
        .word_valid (cmd_valid),
        .word       (cmd_word)
    );

    assign hdr = decode_hdr(cmd_word[WORD_W-1 -: 4]);

    dacdec_regs #(.CODE_W(CODE_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .hdr       (hdr),
        .code      (cmd_word[CODE_W-1:0]),
        .ldn_i     (ldn_i),
        .in_flat   (in_code_o),
        .out_flat  (out_code_o),
        .shdn      (shdn_o)
    );
endmodule

// File: rtl/dacdec_checker.sv
module dacdec_checker #(
    parameter int CODE_W = 12,
    parameter int NCH    = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ldn_i,
    input logic [NCH*CODE_W-1:0] in_code_o,
    input logic [NCH*CODE_W-1:0] out_code_o,
    input logic [NCH-1:0]        shdn_o,
    input logic                  cmd_valid,
    input logic [CODE_W+3:0]     cmd_word
);
    logic                  f_all, f_one;
    logic [1:0]            f_addr;
    logic [NCH-1:0]        sel;
    logic [NCH*CODE_W-1:0] lane_mask, code_rep;

    assign f_all  = cmd_word[CODE_W+3];
    assign f_one  = cmd_word[CODE_W+2];
    assign f_addr = cmd_word[CODE_W+1:CODE_W];
    assign sel    = NCH'(1) << f_addr;
    assign code_rep = {NCH{cmd_word[CODE_W-1:0]}};

    for (genvar c = 0; c < NCH; c++) begin : g_m
        assign lane_mask[c*CODE_W +: CODE_W] = {CODE_W{sel[c]}};
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (&shdn_o) && (in_code_o == '0) && (out_code_o == '0));

    assert_write_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !f_all && !f_one |=>
            ((shdn_o & $past(sel)) == '0) &&
            ((in_code_o & $past(lane_mask)) == ($past(code_rep) & $past(lane_mask))));

    assert_one_shdn_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !f_all && f_one |=>
            ((shdn_o & $past(sel)) == $past(sel)) && $stable(in_code_o));

    assert_all_shdn_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && f_all |=> (&shdn_o) && $stable(in_code_o));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(in_code_o) && $stable(shdn_o));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        !ldn_i |=> out_code_o == $past(in_code_o));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ldn_i |=> $stable(out_code_o));
endmodule

bind dacdec_top dacdec_checker #(.CODE_W(CODE_W), .NCH(4)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ldn_i      (ldn_i),
    .in_code_o  (in_code_o),
    .out_code_o (out_code_o),
    .shdn_o     (shdn_o),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word)
);

// File: tb/dacdec_tb.sv
`timescale 1ns/1ps
module dacdec_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sclk = '0, sdat = '0, csn = '1, ldn = '1;

    always #2.5 clk = ~clk;

    logic [47:0] in16, out16;
    logic [39:0] in10, out10;
    logic [3:0]  sh16, sh10;

    dacdec_top #(.CODE_W(12)) dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk[0]), .sdata_i(sdat[0]),
        .csn_i(csn[0]), .ldn_i(ldn[0]),
        .in_code_o(in16), .out_code_o(out16), .shdn_o(sh16));

    dacdec_top #(.CODE_W(10)) dut10_i (
        .clk(clk), .rst(rst), .sclk_i(sclk[1]), .sdata_i(sdat[1]),
        .csn_i(csn[1]), .ldn_i(ldn[1]),
        .in_code_o(in10), .out_code_o(out10), .shdn_o(sh10));

    logic [11:0] m_in  [2][4];
    logic [11:0] m_out [2][4];
    logic [3:0]  m_sh  [2];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic int cw(input int w);
        return (w == 0) ? 12 : 10;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 4; c++) begin
                m_in[w][c]  = '0;
                m_out[w][c] = '0;
            end
            m_sh[w] = 4'hF;
        end
    endtask

    // R2..R5 reference: flags at c+3, c+2, addr at c+1:c, code below
    task automatic model_apply(input int w, input logic [31:0] word);
        int c;
        logic [1:0] a;
        logic [11:0] code;
        c = cw(w);
        a = word[c+1 -: 2];
        code = 12'(word & ((32'd1 << c) - 1));
        if (word[c+3])
            m_sh[w] = 4'hF;
        else if (word[c+2])
            m_sh[w][a] = 1'b1;
        else begin
            m_in[w][a] = code;
            m_sh[w][a] = 1'b0;
        end
    endtask

    task automatic send(input int w, input logic [31:0] val, input int nbits);
        csn[w] = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdat[w] = val[i];
            wait_clk(4);
            sclk[w] = 1'b1;
            wait_clk(4);
            sclk[w] = 1'b0;
        end
        wait_clk(4);
        csn[w] = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_cmd(input int w, input logic [31:0] val);
        send(w, val, cw(w) + 4);
        model_apply(w, val);
    endtask

    task automatic load(input int w);
        ldn[w] = 1'b0;
        wait_clk(1);
        ldn[w] = 1'b1;
        for (int c = 0; c < 4; c++) m_out[w][c] = m_in[w][c];
        wait_clk(2);
    endtask

    task automatic check_all(input int w, input string tag);
        logic [11:0] ai, ao;
        logic        as;
        for (int c = 0; c < 4; c++) begin
            if (w == 0) begin
                ai = in16[c*12 +: 12]; ao = out16[c*12 +: 12]; as = sh16[c];
            end else begin
                ai = {2'b00, in10[c*10 +: 10]}; ao = {2'b00, out10[c*10 +: 10]}; as = sh10[c];
            end
            checks++;
            if (ai !== m_in[w][c] || ao !== m_out[w][c] || as !== m_sh[w][c]) begin
                fails++;
                $display("FAIL %s dut%0d ch%0d: in/out/shdn act %h/%h/%b exp %h/%h/%b",
                         tag, w, c, ai, ao, as, m_in[w][c], m_out[w][c], m_sh[w][c]);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): act still running exp finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        model_reset();
        wait_clk(5);
        check_all(0, "R1 during reset");
        rst = 1'b0;
        wait_clk(3);
        check_all(0, "R1");
        check_all(1, "R1");

        send_cmd(0, 32'h0ABC);           // write A, code 0xABC
        check_all(0, "R2 R3 write A");
        send_cmd(0, 32'h3123);           // write D
        check_all(0, "R3 write D");
        send_cmd(0, 32'h5FFF);           // single shutdown B, code ignored
        check_all(0, "R4 shdn B");
        send_cmd(0, 32'h4000);           // single shutdown A
        check_all(0, "R4 shdn A");
        load(0);
        check_all(0, "R8 load");
        send_cmd(0, 32'h0555);           // write A after load, outputs hold
        wait_clk(20);
        check_all(0, "R8 hold");
        send_cmd(0, 32'hB777);           // all shutdown, other bits ignored
        check_all(0, "R5 all shdn");
        send_cmd(0, 32'hF000);
        check_all(0, "R5 both flags");
        send(0, 32'h2999, 15);           // short frame
        check_all(0, "R6 short");
        send(0, 32'h12999, 17);          // long frame
        check_all(0, "R6 long");

        for (int i = 0; i < 16; i++) begin   // R7: clocks with chip select high
            sdat[0] = 1'($urandom);
            wait_clk(3);
            sclk[0] = 1'b1;
            wait_clk(3);
            sclk[0] = 1'b0;
        end
        wait_clk(8);
        check_all(0, "R7 idle clocks");
        send_cmd(0, 32'h2321);
        check_all(0, "R7 next frame");

        send_cmd(1, 32'h0BAB);           // R9: write C, 10-bit code 0x3AB
        check_all(1, "R9 write C");
        send_cmd(1, 32'h1C01);           // R9: single shutdown D
        check_all(1, "R9 shdn D");
        send(1, 32'h0155, 16);           // R9: 16-bit frame dropped
        check_all(1, "R9 R6 wrong length");
        load(1);
        check_all(1, "R9 R8 load");
        send_cmd(1, 32'h2000);
        check_all(1, "R9 R5 all shdn");

        for (int i = 0; i < 200; i++) begin
            int w, nb;
            logic [31:0] word;
            w = int'($urandom % 2);
            word = $urandom & ((32'd1 << (cw(w) + 4)) - 1);
            if ($urandom % 2 == 1) word[cw(w)+3] = 1'b0;
            if ($urandom % 2 == 1) word[cw(w)+2] = 1'b0;
            nb = cw(w) + 4;
            case ($urandom % 10)
                0: nb = nb - 1;
                1: nb = nb + 1;
                default: ;
            endcase
            send(w, word, nb);
            if (nb == cw(w) + 4) model_apply(w, word);
            if ($urandom % 4 == 0) load(w);
            check_all(w, (nb == cw(w) + 4) ? "R2 random" : "R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule